// File: doc/BRIEF.md
# Graphics command FIFO register block

This block holds the control and status registers for a graphics command queue kept as a ring buffer in main memory. Software reaches it over a 16-bit big-endian register bus that can also issue 32-bit accesses. Through the bus it sets the ring bounds and the write pointer, picks which conditions may raise the interrupt, and clears sticky fault flags. The command reader outside the block supplies its current read pointer, a strobe carrying each token it takes, a busy indication and a breakpoint event.

From the distance between write and read pointer, taken around the ring, the block keeps a high-level flag and a low-level flag. It also records the last token and drives a single interrupt line. The memory fetch and the command decode live elsewhere.

A 32-bit access is treated as two 16-bit accesses, at the addressed offset and at the offset plus two. The upper half of the bus word maps to the lower offset, as big-endian ordering requires. Each pointer keeps its low 16 bits at its base offset, so a 32-bit write stores the pointer with its halves exchanged.

Top module: `gfx_cmdq_regs`

## Requirements
- R1: Each of the ring start (0x20), ring end (0x24) and write pointer (0x34) is 32 bits wide. A 16-bit write at the base offset sets bits [15:0], a 16-bit write at base+2 sets bits [31:16], and 16-bit reads return the same halves in rdata[15:0].
- R2: A 32-bit access at offset A acts on the halfword at A through bus bits [31:16] and on the halfword at A+2 through bus bits [15:0]. A 32-bit write of value V to a pointer base therefore stores {V[15:0], V[31:16]}.
- R3: The control register (0x02, bits [5:0]) is read/write and resets to 0x15. Bit 5 is breakpoint enable, bit 4 link enable, bit 3 low-level interrupt enable, bit 2 high-level interrupt enable, bit 1 global interrupt enable and bit 0 read enable.
- R4: The status register (0x00) is read-only. Bit 4 is the breakpoint flag, bit 3 command-idle, bit 2 read-idle, bit 1 the low-level flag and bit 0 the high-level flag, and bits [15:5] read 0.
- R5: Occupancy is write pointer minus read pointer when the write pointer is not below the read pointer, and otherwise that difference plus (end minus start). The high-level flag is set one cycle after occupancy is at least HI_MARK, and it stays set until cleared.
- R6: The low-level flag is set one cycle after occupancy is at most LO_MARK, and it stays set until cleared.
- R7: Writing the clear register (0x04) with bit 1 set clears the low-level flag, and with bit 0 set clears the high-level flag. Zero bits have no effect, and a set condition in the same cycle wins over the clear.
- R8: Each token strobe loads the 16-bit token register (0x0E). The token register reads 0 after reset.
- R9: Writes to status and token are ignored. The clear register and all unmapped offsets read 0.
- R10: irq is 1 exactly when global enable is 1 and at least one flag is set with its own enable: high-level with bit 2, low-level with bit 3, breakpoint with bit 5.
- R11: Read-idle is 1 when read enable is 0 or the read pointer equals the write pointer. Command-idle is read-idle with the reader not busy.
- R12: A breakpoint strobe sets the breakpoint flag only while breakpoint enable is 1. The flag clears one cycle after breakpoint enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_wide | input | 1 | 1 for a 32-bit access, 0 for 16-bit |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wdata | input | 32 | Write data (16-bit writes use [15:0]) |
| bus_rdata | output | 32 | Read data (16-bit reads in [15:0]) |
| rd_ptr | input | 32 | Current read pointer of the command reader |
| tok_vld | input | 1 | Token taken this cycle |
| tok_data | input | 16 | Token value |
| cmd_busy | input | 1 | Reader is executing a command |
| bp_hit | input | 1 | Reader reached a breakpoint |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check that irq never rises without global enable, that a set level flag falls only after a clear write naming it, and that the token holds without a strobe. They also check that read-idle follows a disabled reader, that reserved status bits read zero, and that control leaves reset at its defined value. Only the bench scenarios show the halfword swap of 32-bit writes and the occupancy arithmetic across the ring wrap. The same holds for the exact watermark boundaries, set winning over clear, and the breakpoint flag's dependence on its enable.

// File: rtl/gfx_cmdq_regs.sv
module gfx_cmdq_regs #(
  parameter int ADDR_W  = 7,
  parameter logic [31:0] HI_MARK = 32'd64,
  parameter logic [31:0] LO_MARK = 32'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_wide,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       rd_ptr,
  input  logic              tok_vld,
  input  logic [15:0]       tok_data,
  input  logic              cmd_busy,
  input  logic              bp_hit,
  output logic              irq
);
  localparam int HW = ADDR_W - 1;
  localparam logic [HW-1:0] H_STAT = HW'(8'h00 >> 1);
  localparam logic [HW-1:0] H_CTRL = HW'(8'h02 >> 1);
  localparam logic [HW-1:0] H_CLR  = HW'(8'h04 >> 1);
  localparam logic [HW-1:0] H_TOK  = HW'(8'h0E >> 1);
  localparam logic [HW-1:0] H_BEG  = HW'(8'h20 >> 1);
  localparam logic [HW-1:0] H_END  = HW'(8'h24 >> 1);
  localparam logic [HW-1:0] H_WP   = HW'(8'h34 >> 1);
  localparam logic [5:0]    CTRL_RST = 6'b010101;

  logic [5:0]  ctrl_q;
  logic [15:0] tok_q;
  logic [31:0] beg_q, end_q, wp_q;
  logic        hi_q, lo_q, bp_q;

  logic [HW-1:0] h0, h1;
  logic          we0, we1;
  logic [15:0]   wd0, wd1;

  assign h0  = bus_addr[ADDR_W-1:1];
  assign h1  = h0 + HW'(1);
  assign we0 = bus_sel & bus_wr;
  assign we1 = bus_sel & bus_wr & bus_wide;
  assign wd0 = bus_wide ? bus_wdata[31:16] : bus_wdata[15:0];
  assign wd1 = bus_wdata[15:0];

  function automatic logic hit(input logic [HW-1:0] h);
    return (we0 && h0 == h) || (we1 && h1 == h);
  endfunction

  function automatic logic [15:0] dat(input logic [HW-1:0] h);
    return (we0 && h0 == h) ? wd0 : wd1;
  endfunction

  logic [31:0] ring, occ;
  logic        rd_idle, cmd_idle, clr_hi, clr_lo;

  assign ring     = end_q - beg_q;
  assign occ      = (wp_q >= rd_ptr) ? wp_q - rd_ptr : wp_q - rd_ptr + ring;
  assign rd_idle  = ~ctrl_q[0] | (rd_ptr == wp_q);
  assign cmd_idle = rd_idle & ~cmd_busy;
  assign clr_hi   = hit(H_CLR) & dat(H_CLR)[0];
  assign clr_lo   = hit(H_CLR) & dat(H_CLR)[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      tok_q  <= '0;
      beg_q  <= '0;
      end_q  <= '0;
      wp_q   <= '0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      bp_q   <= 1'b0;
    end else begin
      if (hit(H_CTRL))  ctrl_q        <= dat(H_CTRL)[5:0];
      if (hit(H_BEG))   beg_q[15:0]   <= dat(H_BEG);
      if (hit(H_BEG+1)) beg_q[31:16]  <= dat(H_BEG + HW'(1));
      if (hit(H_END))   end_q[15:0]   <= dat(H_END);
      if (hit(H_END+1)) end_q[31:16]  <= dat(H_END + HW'(1));
      if (hit(H_WP))    wp_q[15:0]    <= dat(H_WP);
      if (hit(H_WP+1))  wp_q[31:16]   <= dat(H_WP + HW'(1));
      if (tok_vld)      tok_q         <= tok_data;
      hi_q <= (occ >= HI_MARK) | (hi_q & ~clr_hi);
      lo_q <= (occ <= LO_MARK) | (lo_q & ~clr_lo);
      bp_q <= ctrl_q[5] & (bp_q | bp_hit);
    end
  end

  assign irq = ctrl_q[1] & ((hi_q & ctrl_q[2]) | (lo_q & ctrl_q[3]) | (bp_q & ctrl_q[5]));

  function automatic logic [15:0] rd_half(input logic [HW-1:0] h);
    case (h)
      H_STAT:          return {11'd0, bp_q, cmd_idle, rd_idle, lo_q, hi_q};
      H_CTRL:          return {10'd0, ctrl_q};
      H_TOK:           return tok_q;
      H_BEG:           return beg_q[15:0];
      H_BEG + HW'(1):  return beg_q[31:16];
      H_END:           return end_q[15:0];
      H_END + HW'(1):  return end_q[31:16];
      H_WP:            return wp_q[15:0];
      H_WP + HW'(1):   return wp_q[31:16];
      default:         return 16'd0;
    endcase
  endfunction

  assign bus_rdata = bus_wide ? {rd_half(h0), rd_half(h1)} : {16'd0, rd_half(h0)};
endmodule

// File: rtl/gfx_cmdq_regs_chk.sv
module gfx_cmdq_regs_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              bus_wide,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              tok_vld,
  input logic              irq,
  input logic [5:0]        ctrl_q,
  input logic [15:0]       tok_q,
  input logic              hi_q,
  input logic              rd_idle
);
  logic [ADDR_W-2:0] h;
  logic              clr0;
  assign h = bus_addr[ADDR_W-1:1];
  assign clr0 = bus_sel & bus_wr &
                (((h == (ADDR_W-1)'(2)) & (bus_wide ? bus_wdata[16] : bus_wdata[0])) |
                 (bus_wide & (h == (ADDR_W-1)'(1)) & bus_wdata[0]));

  assert_ctrl_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> ctrl_q == 6'h15);
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q[1]);
  assert_hi_only_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hi_q) |-> $past(clr0));
  assert_token_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_vld |=> $stable(tok_q));
  assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> rd_idle);
  assert_status_rsvd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !bus_wide && h == '0) |-> bus_rdata[15:5] == '0);
endmodule

bind gfx_cmdq_regs gfx_cmdq_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wide(bus_wide),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tok_vld(tok_vld),
  .irq(irq), .ctrl_q(ctrl_q), .tok_q(tok_q), .hi_q(hi_q), .rd_idle(rd_idle)
);

// File: tb/gfx_cmdq_regs_tb_top.sv
module gfx_cmdq_regs_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 0, bus_wr = 0, bus_wide = 0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rd_ptr = '0;
  logic        tok_vld = 0, cmd_busy = 0, bp_hit = 0, irq;
  logic [15:0] tok_data = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gfx_cmdq_regs dut_i (.clk, .rst_n, .bus_sel, .bus_wr, .bus_wide, .bus_addr, .bus_wdata,
    .bus_rdata, .rd_ptr, .tok_vld, .tok_data, .cmd_busy, .bp_hit, .irq);

  // {is_write, wide, addr[6:0], wdata[31:0], expected[31:0]}
  localparam int NV = 17;
  localparam logic [72:0] VEC [NV] = '{
    {1'b0, 1'b0, 7'h02, 32'h0,         32'h0000_0015},  // R3 reset
    {1'b1, 1'b0, 7'h20, 32'h0000_1000, 32'h0},          // R1
    {1'b1, 1'b0, 7'h22, 32'h0000_0000, 32'h0},
    {1'b0, 1'b0, 7'h20, 32'h0,         32'h0000_1000},  // R1
    {1'b0, 1'b1, 7'h20, 32'h0,         32'h1000_0000},  // R2 wide read
    {1'b1, 1'b1, 7'h24, 32'h2000_0000, 32'h0},          // R2 wide write
    {1'b0, 1'b0, 7'h24, 32'h0,         32'h0000_2000},  // R2
    {1'b0, 1'b0, 7'h26, 32'h0,         32'h0000_0000},  // R2
    {1'b1, 1'b1, 7'h34, 32'h1000_0000, 32'h0},          // R2
    {1'b0, 1'b0, 7'h34, 32'h0,         32'h0000_1000},
    {1'b0, 1'b0, 7'h36, 32'h0,         32'h0000_0000},
    {1'b1, 1'b0, 7'h0E, 32'h0000_ABCD, 32'h0},          // R9 token write
    {1'b0, 1'b0, 7'h0E, 32'h0,         32'h0000_0000},  // R8 R9
    {1'b0, 1'b0, 7'h10, 32'h0,         32'h0000_0000},  // R9 unmapped
    {1'b0, 1'b0, 7'h04, 32'h0,         32'h0000_0000},  // R9 clear reads 0
    {1'b1, 1'b0, 7'h26, 32'h0000_0001, 32'h0},          // R1 high half
    {1'b0, 1'b1, 7'h24, 32'h0,         32'h2000_0001}   // R1 R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic wide = 0);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_wide = wide; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wide = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d, input logic wide = 0);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_wide = wide; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0; bus_wide = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R10 irq after reset", {31'd0, irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][70:64], VEC[i][63:32], VEC[i][71]);
      else begin
        rd(VEC[i][70:64], r, VEC[i][71]);
        chk($sformatf("R1/R2/R3/R9 vector %0d", i), r, VEC[i][31:0]);
      end
    end

    wr(7'h26, 32'h0);                 // end = 0x2000
    rd_ptr = 32'h1000; settle();      // occupancy 0
    wr(7'h04, 32'h1); settle();
    rd(7'h00, r);
    chk("R4 R6 R11 status idle+low", r, 32'h0000_000E);
    wr(7'h04, 32'h2); settle();
    rd(7'h00, r);
    chk("R7 set wins over clear", r & 32'h2, 32'h2);

    wr(7'h34, 32'h1040); settle();    // occupancy 64
    wr(7'h04, 32'h2); settle();
    rd(7'h00, r);
    chk("R5 R11 high set, busy", r, 32'h0000_0001);
    wr(7'h34, 32'h1020); settle();    // occupancy 32
    wr(7'h04, 32'h0); settle();
    rd(7'h00, r);
    chk("R7 zero has no effect", r & 32'h1, 32'h1);
    wr(7'h04, 32'h1); settle();
    rd(7'h00, r);
    chk("R5 R7 high cleared", r & 32'h1, 32'h0);

    rd_ptr = 32'h1FF0; wr(7'h34, 32'h102F); settle();   // wrap, occupancy 63
    wr(7'h04, 32'h3); settle();
    rd(7'h00, r);
    chk("R5 wrap below mark", r & 32'h3, 32'h0);
    wr(7'h34, 32'h1030); settle();                      // occupancy 64
    rd(7'h00, r);
    chk("R5 wrap at mark", r & 32'h1, 32'h1);

    rd_ptr = 32'h1000; wr(7'h34, 32'h1009); settle();   // occupancy 9
    wr(7'h04, 32'h3); settle();
    rd(7'h00, r);
    chk("R6 above low mark", r & 32'h3, 32'h0);
    wr(7'h34, 32'h1008); settle();                      // occupancy 8
    rd(7'h00, r);
    chk("R6 at low mark", r & 32'h3, 32'h2);

    chk("R10 global disabled", {31'd0, irq}, 32'd0);
    wr(7'h02, 32'h1F); settle();
    chk("R10 low enabled", {31'd0, irq}, 32'd1);
    wr(7'h02, 32'h17); settle();
    rd(7'h02, r);
    chk("R3 control readback", r, 32'h17);
    chk("R10 low disabled", {31'd0, irq}, 32'd0);

    wr(7'h02, 32'h37);
    @(negedge clk) bp_hit = 1;
    @(negedge clk) bp_hit = 0;
    rd(7'h00, r);
    chk("R12 bp flag", r & 32'h10, 32'h10);
    chk("R10 R12 bp irq", {31'd0, irq}, 32'd1);
    wr(7'h02, 32'h17); settle();
    rd(7'h00, r);
    chk("R12 bp cleared", r & 32'h10, 32'h0);
    @(negedge clk) bp_hit = 1;
    @(negedge clk) bp_hit = 0;
    rd(7'h00, r);
    chk("R12 bp ignored when disabled", r & 32'h10, 32'h0);

    cmd_busy = 1;
    rd(7'h00, r);
    chk("R11 reading, busy", r & 32'hC, 32'h0);
    wr(7'h02, 32'h16); settle();
    rd(7'h00, r);
    chk("R11 read disabled", r & 32'hC, 32'h4);
    cmd_busy = 0;
    rd(7'h00, r);
    chk("R11 cmd idle", r & 32'hC, 32'hC);

    @(negedge clk) begin tok_vld = 1; tok_data = 16'hBEEF; end
    @(negedge clk) tok_vld = 0;
    rd(7'h0E, r);
    chk("R8 token capture", r, 32'h0000_BEEF);
    wr(7'h0E, 32'h1234);
    rd(7'h0E, r);
    chk("R9 token write ignored", r, 32'h0000_BEEF);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule